// File: doc/BRIEF.md
# Biphase-Mark Audio Frame Transmitter

This block turns a stream of stereo PCM samples into a consumer digital-audio line signal on a single output wire. Left and right samples each arrive with their own load strobe. They are copied into the transmit path once per frame. If a channel gets no new sample before a frame starts, its previous value is sent again. Each frame carries two sub-frames, left first and right second. A sub-frame has 32 slots: a 4-slot sync preamble, the 24-bit audio field, a validity flag, a user bit that is always zero, one channel-status bit and an even-parity bit.

The output is biphase-mark coded, so each slot is two line states. A state lasts `HALF_DIV` clocks, which makes the line-state rate `clk / HALF_DIV` and places it at 128 times the sample rate. Frames are grouped into blocks of 192. The channel-status vector (42 bits) and the stereo flag are captured at the start of each block. Frame n of a block sends status bit n in both sub-frames.

In consumer mode with stereo set, status bits 20 to 23 are patched so that each sub-frame identifies its own channel. Deasserting `tx_en` forces the line low. Reasserting it always restarts the stream at frame 0 with a block preamble.

Top module: `bmc_audio_tx`

## Requirements
- R1: While `tx_en` is low, `line_out` is 0 from the clock after `tx_en` is sampled low, whatever the other inputs do. Strobed loads are still captured during this time.
- R2: On the clock after `tx_en` is sampled high following a disabled period, the first line state of frame 0, sub-frame 1 appears. Every line state then lasts exactly `HALF_DIV` clocks.
- R3: A block is 192 frames of 2 sub-frames, and each sub-frame is 64 line states. Frame 0 sub-frame 1 starts with preamble B. Every other first sub-frame starts with M. Every second sub-frame starts with W.
- R4: The 8 preamble states, in time order, are B=11101000, M=11100010 and W=11100100 when the line state just before the preamble is 0. When that state is 1, all 8 states are inverted.
- R5: In slots 4 to 31, every slot begins with a line transition. A slot carrying 1 changes level again at mid-slot, and a slot carrying 0 does not.
- R6: Slots 4 to 27 carry the sample LSB first, so the MSB is in slot 27. The left sample goes in sub-frame 1 and the right sample in sub-frame 2. Slot 28 carries the validity input (1 = unreliable). Slot 29 is always 0.
- R7: Slot 31 makes the number of ones in slots 4 to 31 even.
- R8: Slot 30 of frame n carries status bit n in both sub-frames, and is 0 for n above 41. The status vector is captured at block start, so changes during a block take effect at the next frame 0.
- R9: When status bit 0 is 0 (consumer mode), slot 30 of frames 20 to 23 is overridden by the stereo flag captured at block start. With the flag set, the values are 1,0,0,0 in sub-frame 1 and 0,1,0,0 in sub-frame 2. With the flag clear, all are 0.
- R10: Samples and the validity flag are taken at each frame start from the most recent load (or level, for validity). A channel with no new load repeats its last sample.
- R11: When status bit 0 is 1, bits 20 to 23 are sent unmodified from the status vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one line state lasts HALF_DIV cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable; low forces the line low and rewinds to frame 0 |
| left_data | input | SAMPLE_W | Left sample, two's complement |
| left_load | input | 1 | Captures left_data |
| right_data | input | SAMPLE_W | Right sample, two's complement |
| right_load | input | 1 | Captures right_data |
| invalid_in | input | 1 | Validity flag for the next frame (1 = unreliable) |
| cs_in | input | CS_BITS | Channel-status vector, bit n goes out in frame n |
| stereo_in | input | 1 | Enables stereo channel numbering in status bits 20 to 23 |
| line_out | output | 1 | Biphase-mark coded serial output |

## Verification
The first line state is due one clock after `tx_en` is sampled high. Every following state changes one clock after each group of `HALF_DIV` rising edges. The bench therefore samples `line_out` on every falling edge and requires all `HALF_DIV` samples of a state to agree.

A disable shows on the line one clock later, so it is checked from the next falling edge on. New samples and the validity level are driven in the middle of the second sub-frame and are expected in the frame that follows. A status change made mid-block is expected only after the next frame 0. Expected slot contents, parity and preamble polarity are rebuilt in bench functions from the previous decoded line state.

// File: rtl/bmc_audio_tx.sv
`timescale 1ns/1ps
module bmc_audio_tx #(
  parameter int SAMPLE_W = 24,
  parameter int CS_BITS  = 42,
  parameter int FRAMES   = 192,
  parameter int HALF_DIV = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tx_en,
  input  logic [SAMPLE_W-1:0] left_data,
  input  logic                left_load,
  input  logic [SAMPLE_W-1:0] right_data,
  input  logic                right_load,
  input  logic                invalid_in,
  input  logic [CS_BITS-1:0]  cs_in,
  input  logic                stereo_in,
  output logic                line_out
);
  localparam int AUD_W = 24;
  localparam int PAD   = AUD_W - SAMPLE_W;
  localparam int FR_W  = $clog2(FRAMES);
  localparam int DIV_W = $clog2(HALF_DIV + 1);
  localparam logic [7:0] PRE_B = 8'b11101000;
  localparam logic [7:0] PRE_M = 8'b11100010;
  localparam logic [7:0] PRE_W = 8'b11100100;

  logic [DIV_W-1:0]    div_q;
  logic                idle_q, sub_q, line_q, pol_q, par_q;
  logic [5:0]          st_q;
  logic [FR_W-1:0]     frame_q;
  logic [SAMPLE_W-1:0] l_pend, r_pend, l_hold, r_hold;
  logic                inv_hold, stereo_hold;
  logic [CS_BITS-1:0]  cs_hold;

  logic            tick, n_sub, frame_start, block_start;
  logic [5:0]      n_st;
  logic [4:0]      n_slot;
  logic [FR_W-1:0] n_frame;
  logic [AUD_W-1:0] aud;
  logic [7:0]      pat;
  logic            cs_bit, dbit, line_nx, par_nx;

  assign tick    = tx_en && (div_q == DIV_W'(HALF_DIV - 1));
  assign n_st    = idle_q ? 6'd0 : st_q + 6'd1;
  assign n_sub   = idle_q ? 1'b0 : (st_q == 6'd63 ? ~sub_q : sub_q);
  assign n_frame = idle_q ? '0 :
                   (st_q == 6'd63 && sub_q) ? (frame_q == FR_W'(FRAMES - 1) ? '0 : frame_q + FR_W'(1)) :
                   frame_q;
  assign n_slot  = n_st[5:1];
  assign frame_start = tick && n_st == 6'd0 && !n_sub;
  assign block_start = frame_start && n_frame == '0;
  assign aud = AUD_W'(n_sub ? r_hold : l_hold) << PAD;
  assign pat = n_sub ? PRE_W : (n_frame == '0 ? PRE_B : PRE_M);

  always_comb begin
    cs_bit = |(cs_hold & (CS_BITS'(1) << n_frame));
    if (!cs_hold[0] && n_frame >= FR_W'(20) && n_frame <= FR_W'(23))
      cs_bit = stereo_hold && (n_sub ? n_frame == FR_W'(21) : n_frame == FR_W'(20));
  end

  always_comb begin
    if (n_slot <= 5'd27)      dbit = |(aud & (AUD_W'(1) << (n_slot - 5'd4)));
    else if (n_slot == 5'd28) dbit = inv_hold;
    else if (n_slot == 5'd29) dbit = 1'b0;
    else if (n_slot == 5'd30) dbit = cs_bit;
    else                      dbit = par_q;
  end

  always_comb begin
    if (n_st < 6'd8)
      line_nx = (n_st == 6'd0) ? pat[7] ^ line_q : pat[3'd7 - n_st[2:0]] ^ pol_q;
    else if (!n_st[0])
      line_nx = ~line_q;
    else
      line_nx = line_q ^ dbit;
    par_nx = par_q;
    if (n_st >= 6'd8 && !n_st[0] && n_slot <= 5'd30)
      par_nx = (n_slot == 5'd4) ? dbit : par_q ^ dbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_pend <= '0;
      r_pend <= '0;
    end else begin
      if (left_load)  l_pend <= left_data;
      if (right_load) r_pend <= right_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_W'(HALF_DIV - 1);
      idle_q <= 1'b1;
      st_q <= '0;
      sub_q <= 1'b0;
      frame_q <= '0;
      line_q <= 1'b0;
      pol_q <= 1'b0;
      par_q <= 1'b0;
      l_hold <= '0;
      r_hold <= '0;
      inv_hold <= 1'b0;
      cs_hold <= '0;
      stereo_hold <= 1'b0;
    end else if (!tx_en) begin
      div_q <= DIV_W'(HALF_DIV - 1);
      idle_q <= 1'b1;
      line_q <= 1'b0;
    end else if (tick) begin
      div_q <= '0;
      idle_q <= 1'b0;
      st_q <= n_st;
      sub_q <= n_sub;
      frame_q <= n_frame;
      line_q <= line_nx;
      par_q <= par_nx;
      if (n_st == 6'd0) pol_q <= line_q;
      if (frame_start) begin
        l_hold <= l_pend;
        r_hold <= r_pend;
        inv_hold <= invalid_in;
      end
      if (block_start) begin
        cs_hold <= cs_in;
        stereo_hold <= stereo_in;
      end
    end else begin
      div_q <= div_q + DIV_W'(1);
    end
  end

  assign line_out = line_q;

  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !line_out);
  a_r2_state_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !tick) |=> $stable(line_out));
  a_r2_restart_frame0: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && idle_q) |=> (frame_q == '0 && !sub_q && st_q == 6'd0));
  a_r3_frame_range: assert property (@(posedge clk) disable iff (!rst_n)
    frame_q < FR_W'(FRAMES));
  a_r10_hold_at_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(l_hold) |-> $past(frame_start));
endmodule

// File: tb/tb_bmc_audio_tx.sv
`timescale 1ns/1ps
module tb_bmc_audio_tx;
  localparam int HD = 2;
  localparam int SW = 24;
  localparam int CSB = 42;
  localparam int NFR = 192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0;
  logic [SW-1:0] left_data = '0, right_data = '0;
  logic left_load = 1'b0, right_load = 1'b0;
  logic invalid_in = 1'b0;
  logic [CSB-1:0] cs_in = '0;
  logic stereo_in = 1'b0;
  logic line_out;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  bit [SW-1:0]  m_pend_l, m_pend_r;
  bit [CSB-1:0] cs_drive, cs_now;
  bit           st_drive, st_now, inv_drive;

  always #4 clk = ~clk;

  bmc_audio_tx #(.SAMPLE_W(SW), .CS_BITS(CSB), .FRAMES(NFR), .HALF_DIV(HD)) dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en),
    .left_data(left_data), .left_load(left_load),
    .right_data(right_data), .right_load(right_load),
    .invalid_in(invalid_in), .cs_in(cs_in), .stereo_in(stereo_in),
    .line_out(line_out));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_cs(int n, bit sub, bit [CSB-1:0] cs, bit stereo);
    if (n >= CSB) return 1'b0;
    if (!cs[0] && n >= 20 && n <= 23) return stereo && ((!sub && n == 20) || (sub && n == 21));
    return cs[n];
  endfunction

  function automatic bit [7:0] exp_pre(int fi, bit sub, bit prev);
    bit [7:0] p;
    p = sub ? 8'b11100100 : (fi == 0 ? 8'b11101000 : 8'b11100010);
    return p ^ {8{prev}};
  endfunction

  task automatic random_loads();
    if ($urandom_range(3) != 0) begin
      left_data = SW'($urandom);
      left_load = 1'b1;
      m_pend_l = left_data;
    end
    if ($urandom_range(3) != 0) begin
      right_data = SW'($urandom);
      right_load = 1'b1;
      m_pend_r = right_data;
    end
    inv_drive = 1'($urandom);
    invalid_in = inv_drive;
  endtask

  task automatic cap_sub(output bit [63:0] s, input bit do_load);
    bit stable_ok;
    bit v0;
    stable_ok = 1;
    for (int k = 0; k < 64; k++) begin
      for (int h = 0; h < HD; h++) begin
        @(negedge clk);
        if (h == 0) v0 = line_out;
        else if (line_out !== v0) stable_ok = 0;
        if (do_load && k == 31 && h == 0) begin
          left_load = 1'b0;
          right_load = 1'b0;
        end
        if (do_load && k == 30 && h == 0) random_loads();
      end
      s[k] = v0;
    end
    chk(stable_ok, "R2", "line state held for HALF_DIV clocks", 0, 1);
  endtask

  task automatic check_sub(input bit [63:0] s, input int fi, input bit sub, input bit prev,
                           input bit [SW-1:0] smp, input bit inv);
    bit [7:0] pre;
    bit [31:0] d;
    bit edges_ok;
    bit ce;
    string tag;
    for (int k = 0; k < 8; k++) pre[7-k] = s[k];
    chk(pre == exp_pre(fi, sub, prev), "R3 R4", $sformatf("preamble frame %0d sub %0d", fi, sub),
        pre, exp_pre(fi, sub, prev));
    edges_ok = 1;
    d = '0;
    for (int j = 4; j < 32; j++) begin
      if (s[2*j] == s[2*j-1]) edges_ok = 0;
      d[j] = s[2*j] ^ s[2*j+1];
    end
    chk(edges_ok, "R5", "slot boundary transitions", 0, 1);
    chk(d[27:4] == smp, "R6 R10", $sformatf("sample frame %0d sub %0d", fi, sub), d[27:4], smp);
    chk(d[28] == inv, "R6 R10", "validity slot", d[28], inv);
    chk(d[29] == 1'b0, "R6", "user slot", d[29], 0);
    ce = exp_cs(fi, sub, cs_now, st_now);
    tag = (fi >= 20 && fi <= 23) ? (cs_now[0] ? "R11" : "R9") : "R8";
    chk(d[30] == ce, tag, $sformatf("status bit frame %0d sub %0d", fi, sub), d[30], ce);
    chk((^d[31:4]) == 1'b0, "R7", "even parity slots 4..31", d[31:4], 0);
  endtask

  task automatic run_frames(input int nfr, input int flip_at);
    bit [63:0] s;
    bit prev;
    bit [SW-1:0] hl, hr;
    bit hv;
    prev = 0;
    for (int f = 0; f < nfr; f++) begin
      int fi;
      fi = f % NFR;
      if (f == flip_at) begin
        cs_drive = ~cs_drive;
        cs_in = cs_drive;
      end
      if (fi == 0) begin
        cs_now = cs_drive;
        st_now = st_drive;
      end
      hl = m_pend_l;
      hr = m_pend_r;
      hv = inv_drive;
      for (int sb = 0; sb < 2; sb++) begin
        cap_sub(s, sb == 1);
        check_sub(s, fi, sb[0], prev, sb == 0 ? hl : hr, hv);
        prev = s[63];
      end
    end
  endtask

  task automatic go_idle_check(input string what);
    bit ok;
    @(negedge clk);
    tx_en = 1'b0;
    ok = 1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (line_out !== 1'b0) ok = 0;
    end
    chk(ok, "R1", what, line_out, 0);
  endtask

  initial begin
    bit ok;
    void'($urandom(32'h5eed_4a11));
    repeat (3) @(negedge clk);
    chk(line_out === 1'b0, "R1", "line low in reset", line_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(line_out === 1'b0, "R1", "line low after reset", line_out, 0);

    ok = 1;
    for (int i = 0; i < 20; i++) begin
      random_loads();
      cs_in = CSB'({$urandom, $urandom});
      stereo_in = 1'($urandom);
      @(negedge clk);
      left_load = 1'b0;
      right_load = 1'b0;
      if (line_out !== 1'b0) ok = 0;
      @(negedge clk);
      if (line_out !== 1'b0) ok = 0;
    end
    chk(ok, "R1", "line low while disabled with busy inputs", line_out, 0);

    cs_drive = CSB'({$urandom, $urandom});
    cs_drive[0] = 1'b0;
    st_drive = 1'b1;
    cs_in = cs_drive;
    stereo_in = st_drive;
    tx_en = 1'b1;
    run_frames(NFR + 2, 60);

    go_idle_check("line low after mid-frame disable");
    cs_drive = CSB'({$urandom, $urandom});
    cs_drive[0] = 1'b0;
    st_drive = 1'b0;
    cs_in = cs_drive;
    stereo_in = st_drive;
    tx_en = 1'b1;
    run_frames(25, -1);

    go_idle_check("line low before professional run");
    cs_drive = CSB'({$urandom, $urandom});
    cs_drive[0] = 1'b1;
    cs_drive[23:20] = 4'b1011;
    st_drive = 1'b1;
    cs_in = cs_drive;
    stereo_in = st_drive;
    tx_en = 1'b1;
    run_frames(25, -1);

    go_idle_check("line low at end");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule